// File: doc/BRIEF.md
# Modem Handshake Status and Change Detector

This block watches the four active-low handshake lines of a serial port (clear to send, data set ready, ring indicator and carrier detect) and presents them as one 8-bit status byte. The upper nibble shows the present asserted state of each line. The lower nibble holds sticky change flags that tell software which lines moved since the byte was last read. Whenever a flag is set and the handshake interrupt is enabled, the block raises an interrupt request. That request goes to a separate priority encoder, which this block does not include.

The four pins are asynchronous. Each one passes through a synchronizer before any edge is detected. Reading the status byte returns the flags and then clears them. If a new change lands in the same cycle as the read, it is kept for the next read. In loopback mode the pins are ignored. The level bits are then taken from four modem-control outputs of the port, so the interrupt path can be tested without any external wiring.

Top module: `modem_delta_detect`

## Requirements
- R1: Status bits 4, 5, 6 and 7 show the complement of the synchronized clear-to-send, data-set-ready, ring and carrier-detect pins respectively, so a low pin reads as 1. A pin change driven just after a clock edge appears in these bits after the second following edge.
- R2: Flag bits 0 (clear to send), 1 (data set ready) and 3 (carrier detect) set on either direction of change of their level bit. The flag is visible one clock edge after the level bit changes.
- R3: Flag bit 2 sets only when the ring level bit goes from 1 to 0, which happens when the ring pin returns high. A 0-to-1 change of the ring level leaves bit 2 clear.
- R4: A set flag stays set, whatever its line does afterwards, until the status byte is read.
- R5: A read is a one-cycle strobe. The byte seen during the strobe cycle carries the flags as they were, and bits 0 to 3 are zero after that cycle's edge. Bits 4 to 7 are not changed by a read.
- R6: A change whose flag would set at the same edge that ends a read is kept, so that flag reads 1 after the read.
- R7: The interrupt request is high exactly when the enable input is high and at least one of bits 0 to 3 is set. With the enable low the request stays low.
- R8: When loopback is on, bits 4 to 7 take the values of the request-to-send, terminal-ready, output-1 and output-2 control bits respectively, in the same cycle and without synchronization. Pin activity then has no effect on any status bit.
- R9: Master reset, which is synchronous and active high, clears bits 0 to 3 and holds the interrupt request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous master reset, active high |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Loopback mode: level bits come from the control bits |
| ctl_rts | input | 1 | Request-to-send control bit, looped to bit 4 |
| ctl_dtr | input | 1 | Terminal-ready control bit, looped to bit 5 |
| ctl_out1 | input | 1 | Output-1 control bit, looped to bit 6 |
| ctl_out2 | input | 1 | Output-2 control bit, looped to bit 7 |
| stat_rd | input | 1 | One-cycle read strobe of the status byte |
| hs_irq_en | input | 1 | Handshake interrupt enable |
| stat_q | output | 8 | Status byte: flags in bits 3:0, levels in bits 7:4 |
| hs_irq | output | 1 | Handshake interrupt request |

## Verification
If the previous-level register holds a wrong value, a flag sets with no pin change. It shows one edge after the level bits settle and is held until the next read. A stuck or miswired synchronizer stage shows as level bits that lag by an extra cycle or never move. The directed tests sample at exact edge counts, so such a stage is caught within the three cycles after a pin change. A broken clear path shows up on the first read after the strobe. Either the flags are still set, or a change that arrived during the read is gone.

// File: rtl/mdd_pkg.sv
package mdd_pkg;
   localparam int unsigned LINES = 4;
   localparam int unsigned STAT_W = 2 * LINES;

   typedef enum int unsigned {
      LN_CTS = 0,
      LN_DSR = 1,
      LN_RI  = 2,
      LN_DCD = 3
   } line_e;

   typedef logic [LINES-1:0] line_vec_t;

   // one bit per line set when only a fall of the level is a change
   localparam line_vec_t TRAIL_ONLY_RI = line_vec_t'(1) << LN_RI;
endpackage

// File: rtl/mdd_sync.sv
module mdd_sync #(
   parameter int unsigned WIDTH   = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdd_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mdd_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= {WIDTH{RST_VAL}};
               else     chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= {WIDTH{RST_VAL}};
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdd_edge.sv
module mdd_edge #(
   parameter int unsigned      WIDTH      = 4,
   parameter logic [WIDTH-1:0] TRAIL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] hit
);
   logic [WIDTH-1:0] lvl_prev;

   always_ff @(posedge clk) begin
      if (rst) lvl_prev <= '0;
      else     lvl_prev <= lvl;
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_line
         if (TRAIL_MASK[i]) begin : g_trail
            assign hit[i] = lvl_prev[i] & ~lvl[i];
         end else begin : g_any
            assign hit[i] = lvl_prev[i] ^ lvl[i];
         end
      end
   endgenerate
endmodule

// File: rtl/mdd_flags.sv
module mdd_flags #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] hit,
   input  logic             clr,
   output logic [WIDTH-1:0] flags
);
   logic [WIDTH-1:0] keep;

   assign keep = clr ? '0 : flags;

   always_ff @(posedge clk) begin
      if (rst) flags <= '0;
      else     flags <= keep | hit;
   end
endmodule

// File: rtl/modem_delta_detect.sv
module modem_delta_detect #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          RI_TRAIL_ONLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cts_n,
   input  logic       dsr_n,
   input  logic       ri_n,
   input  logic       dcd_n,
   input  logic       loop_en,
   input  logic       ctl_rts,
   input  logic       ctl_dtr,
   input  logic       ctl_out1,
   input  logic       ctl_out2,
   input  logic       stat_rd,
   input  logic       hs_irq_en,
   output logic [7:0] stat_q,
   output logic       hs_irq
);
   import mdd_pkg::*;

   localparam line_vec_t TRAIL_MASK = RI_TRAIL_ONLY ? TRAIL_ONLY_RI : '0;

   generate
      if (STAT_W != 8) begin : g_bad_stat
         $error("modem_delta_detect: status byte must be 8 bits");
      end
   endgenerate

   line_vec_t pin_n, pin_sync_n, loop_lvl, lvl, hit, flags;

   assign pin_n[LN_CTS] = cts_n;
   assign pin_n[LN_DSR] = dsr_n;
   assign pin_n[LN_RI]  = ri_n;
   assign pin_n[LN_DCD] = dcd_n;

   assign loop_lvl[LN_CTS] = ctl_rts;
   assign loop_lvl[LN_DSR] = ctl_dtr;
   assign loop_lvl[LN_RI]  = ctl_out1;
   assign loop_lvl[LN_DCD] = ctl_out2;

   mdd_sync #(
      .WIDTH   (LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_n),
      .q   (pin_sync_n)
   );

   assign lvl = loop_en ? loop_lvl : ~pin_sync_n;

   mdd_edge #(
      .WIDTH      (LINES),
      .TRAIL_MASK (TRAIL_MASK)
   ) u_edge (
      .clk (clk),
      .rst (rst),
      .lvl (lvl),
      .hit (hit)
   );

   mdd_flags #(
      .WIDTH (LINES)
   ) u_flags (
      .clk   (clk),
      .rst   (rst),
      .hit   (hit),
      .clr   (stat_rd),
      .flags (flags)
   );

   assign stat_q = {lvl, flags};
   assign hs_irq = hs_irq_en & (|flags);
endmodule

// File: rtl/mdd_chk.sv
module mdd_chk (
   input logic       clk,
   input logic       rst,
   input logic       stat_rd,
   input logic       hs_irq_en,
   input logic [7:0] stat_q,
   input logic       hs_irq
);
   // R9
   reset_clears_flags_chk: assert property (@(posedge clk)
      rst |=> (stat_q[3:0] == 4'b0000 && !hs_irq));

   // R4
   flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      !stat_rd |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

   // R3
   ring_trailing_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_q[2]) |-> ($past(stat_q[6]) == 1'b0 && $past(stat_q[6], 2) == 1'b1));

   // R7
   irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
      !hs_irq_en |-> !hs_irq);

   // R7
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
      hs_irq |-> (stat_q[3:0] != 4'b0000));
endmodule

bind modem_delta_detect mdd_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .stat_rd   (stat_rd),
   .hs_irq_en (hs_irq_en),
   .stat_q    (stat_q),
   .hs_irq    (hs_irq)
);

// File: tb/modem_delta_detect_test.sv
module modem_delta_detect_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] pins_n = 4'hF;
   logic       loop_en = 1'b0;
   logic [3:0] ctl = 4'h0;
   logic       stat_rd = 1'b0;
   logic       hs_irq_en = 1'b0;
   logic [7:0] stat_q;
   logic       hs_irq;
   int         n_checks = 0;
   int         n_fails = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   modem_delta_detect uut (
      .clk       (clk),
      .rst       (rst),
      .cts_n     (pins_n[0]),
      .dsr_n     (pins_n[1]),
      .ri_n      (pins_n[2]),
      .dcd_n     (pins_n[3]),
      .loop_en   (loop_en),
      .ctl_rts   (ctl[0]),
      .ctl_dtr   (ctl[1]),
      .ctl_out1  (ctl[2]),
      .ctl_out2  (ctl[3]),
      .stat_rd   (stat_rd),
      .hs_irq_en (hs_irq_en),
      .stat_q    (stat_q),
      .hs_irq    (hs_irq)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // strobe a read for one cycle; returns the byte seen during the strobe
   task automatic do_read(output logic [7:0] got);
      stat_rd = 1'b1;
      #1;
      got = stat_q;
      tick();
      stat_rd = 1'b0;
   endtask

   task automatic t_reset();
      tick(4);
      check("R9 flags and levels in reset", stat_q, 8'h00);
      check("R9 irq in reset", {7'b0, hs_irq}, 8'h00);
      rst = 1'b0;
      tick();
      check("R9 after reset", stat_q, 8'h00);
   endtask

   // line idx: a fall of the pin then a rise, each flagged
   task automatic t_line(input int idx);
      logic [7:0] got;
      logic [7:0] lv;
      lv = 8'h10 << idx;
      pins_n[idx] = 1'b0;
      tick(2);
      check("R1 level bit after two edges", stat_q, lv);
      tick();
      check("R2 flag after level", stat_q, lv | (8'h01 << idx));
      pins_n[idx] = 1'b1;
      tick(4);
      check("R4 flag held after line returns", stat_q, 8'h01 << idx);
      do_read(got);
      check("R5 read data carries flag", got, 8'h01 << idx);
      check("R5 flags clear after read", stat_q, 8'h00);
   endtask

   task automatic t_ring();
      logic [7:0] got;
      pins_n[2] = 1'b0;
      tick(2);
      check("R1 ring level", stat_q, 8'h40);
      tick(3);
      check("R3 rising ring level no flag", stat_q, 8'h40);
      pins_n[2] = 1'b1;
      tick(2);
      check("R3 ring level dropped", stat_q, 8'h00);
      tick();
      check("R3 trailing ring flag", stat_q, 8'h04);
      do_read(got);
      check("R3 read clears ring flag", stat_q, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] got;
      pins_n[0] = 1'b0;
      tick(3);
      check("R2 cts flag before collide", stat_q, 8'h11);
      pins_n[1] = 1'b0;
      tick(2);
      // dsr level just changed; its flag sets at the edge ending this read
      do_read(got);
      check("R6 read data before new change", got, 8'h31);
      check("R6 new change kept, old cleared", stat_q, 8'h32);
      do_read(got);
      check("R5 read leaves levels", stat_q, 8'h30);
      pins_n[1:0] = 2'b11;
      tick(3);
      do_read(got);
      check("R5 return to idle", stat_q, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] got;
      pins_n[3] = 1'b0;
      tick(3);
      check("R7 no irq when disabled", {7'b0, hs_irq}, 8'h00);
      hs_irq_en = 1'b1;
      #1;
      check("R7 irq with flag and enable", {7'b0, hs_irq}, 8'h01);
      do_read(got);
      check("R7 irq drops after read", {7'b0, hs_irq}, 8'h00);
      pins_n[3] = 1'b1;
      tick(3);
      check("R7 irq on second change", {7'b0, hs_irq}, 8'h01);
      do_read(got);
      hs_irq_en = 1'b0;
      check("R7 idle", {7'b0, hs_irq}, 8'h00);
   endtask

   task automatic t_loop();
      logic [7:0] got;
      loop_en = 1'b1;
      tick(2);
      check("R8 loopback idle", stat_q, 8'h00);
      ctl = 4'b0101;
      #1;
      check("R8 levels follow control same cycle", stat_q, 8'h50);
      tick();
      check("R8 flags from control", stat_q, 8'h51);
      do_read(got);
      pins_n = 4'h0;
      tick(5);
      check("R8 pins ignored in loopback", stat_q, 8'h50);
      ctl = 4'b1010;
      tick();
      check("R8 swapped control bits", stat_q, 8'hAF);
      do_read(got);
      ctl = 4'b0000;
      tick();
      do_read(got);
      pins_n = 4'hF;
      tick(3);
      loop_en = 1'b0;
      tick(3);
      do_read(got);
      check("R8 leave loopback clean", stat_q, 8'h00);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      t_reset();
      t_line(0);
      t_line(1);
      t_line(3);
      t_ring();
      t_collide();
      t_irq();
      t_loop();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end
endmodule